// File: doc/BRIEF.md
# Halt and Reset Vector Controller

This block keeps track of whether the CPU is running or parked in halt, and picks which program-memory vector the CPU fetches after a reset. Software parks the CPU by writing 1 to a halt bit in a standby control register. While the CPU is halted, the CPU clock is gated low and the system clock keeps running for the peripherals. The halt bit clears itself on the falling edge of the system clock after a watchdog interrupt, or after any interrupt request whose enable bit is set. The gate follows the bit, so the CPU clock starts again from that edge.

While the system reset is active, the block notes the cause of the reset. Hardware causes are power-on, oscillation-stop, watchdog overflow and the external pin. Each of these selects the vector at word 0002H. A software break reset selects the vector at word 0004H. It falls back to 0002H when the saved interrupt level is 2 or more. After reset releases, the block presents the low vector word address for one cycle and then the high word address for one cycle, with a valid strobe during both.

Top module: `halt_vec_ctrl`

## Requirements
- R1: When any bit of `hw_cause_i` is set during reset, the vector address pair after release is 0002H then 0003H. The bits are 0 for power-on, 1 for oscillation-stop, 2 for watchdog overflow and 3 for the pin. A hardware cause takes precedence over a break reset.
- R2: A break reset (`brk_rst_i`=1, no hardware cause) with `brk_lvl_i` below 2 gives the address pair 0004H then 0005H.
- R3: A break reset with `brk_lvl_i` of 2 or more gives the address pair 0002H then 0003H.
- R4: The addresses appear in this sequence. On the first rising clock edge after `rst_ni` releases, `vec_valid_o` goes high with the low word address. On the next edge the address becomes low+1. On the edge after that, `vec_valid_o` goes low and `vec_addr_o` reads 0. `vec_valid_o` is low during reset.
- R5: A write with `reg_wdata_i` bit 0 = 1 sets the halt bit on the next falling edge. While halted, `halt_o`=1 and `cpu_clk_o` stays low even when `clk_i` is high.
- R6: `wdt_irq_i` clears the halt bit on the falling edge that follows it, and not before that edge.
- R7: A request on `irq_req_i[k]` clears the halt bit only if `irq_en_i[k]` is 1. A request that is not enabled leaves the CPU halted.
- R8: If an enabled request is already pending when halt is written, halt is set on the write's falling edge and cleared on the following falling edge.
- R9: Asserting `rst_ni` low clears the halt bit, and `cpu_clk_o` follows `clk_i` again.
- R10: `cpu_clk_o` changes only together with `clk_i`. The gate opens or closes only while `clk_i` is low.
- R11: `reg_rdata_o` returns the halt bit in bit 0 and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| hw_cause_i | input | 4 | Hardware reset causes: power-on, oscillation-stop, watchdog overflow, pin |
| brk_rst_i | input | 1 | Reset caused by the break instruction |
| brk_lvl_i | input | LVL_W (2) | Saved interrupt level at break time |
| reg_we_i | input | 1 | Standby control register write strobe |
| reg_wdata_i | input | DATA_W (8) | Register write data |
| reg_rdata_o | output | DATA_W (8) | Register read data |
| wdt_irq_i | input | 1 | Watchdog interrupt request |
| irq_req_i | input | EN_REGS*EN_BITS (56) | Interrupt requests |
| irq_en_i | input | EN_REGS*EN_BITS (56) | Interrupt enable bits |
| cpu_clk_o | output | 1 | Gated CPU clock |
| halt_o | output | 1 | Halt bit state |
| vec_addr_o | output | ADDR_W (16) | Vector word address |
| vec_valid_o | output | 1 | Vector address valid |

## Verification
The bench builds the block with 2 enable registers of 4 bits each, which gives 8 request lines. With only 8 lines, every request line can be tested both enabled and masked against a halted CPU, including the top line where a width slip would show. The break-level fallback is tested at levels 1, 2 and 3 so that the comparison boundary is covered. A monitor on the gated clock checks the time of each of its edges against the phase of the system clock.

// File: rtl/halt_vec_pkg.sv
`timescale 1ns/1ps
package halt_vec_pkg;
  typedef enum logic [1:0] {
    VS_RST  = 2'd0,
    VS_LO   = 2'd1,
    VS_HI   = 2'd2,
    VS_DONE = 2'd3
  } vec_state_e;
endpackage

// File: rtl/hvc_vec_sel.sv
`timescale 1ns/1ps
module hvc_vec_sel
  import halt_vec_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LVL_W       = 2,
  parameter int N_HW        = 4,
  parameter int HW_VEC      = 2,
  parameter int BRK_VEC     = 4,
  parameter int BRK_MAX_LVL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HW-1:0]   hw_cause_i,
  input  logic              brk_rst_i,
  input  logic [LVL_W-1:0]  brk_lvl_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              vec_valid_o
);
  localparam logic [LVL_W-1:0]  LvlLim  = LVL_W'(BRK_MAX_LVL);
  localparam logic [ADDR_W-1:0] HwBase  = ADDR_W'(HW_VEC);
  localparam logic [ADDR_W-1:0] BrkBase = ADDR_W'(BRK_VEC);

  vec_state_e st_q;
  logic       use_brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= VS_RST;
    else begin
      unique case (st_q)
        VS_RST:  st_q <= VS_LO;
        VS_LO:   st_q <= VS_HI;
        default: st_q <= VS_DONE;
      endcase
    end
  end

  // cause sampled on every edge while held in reset state
  always_ff @(posedge clk_i) begin
    if (st_q == VS_RST)
      use_brk_q <= brk_rst_i && !(|hw_cause_i) && (brk_lvl_i < LvlLim);
  end

  always_comb begin
    vec_valid_o = (st_q == VS_LO) || (st_q == VS_HI);
    vec_addr_o  = '0;
    if (vec_valid_o)
      vec_addr_o = (use_brk_q ? BrkBase : HwBase) + ADDR_W'(st_q == VS_HI);
  end

  a_r4_hi_follows_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == VS_LO) |=> (vec_valid_o && vec_addr_o == $past(vec_addr_o) + 1'b1));
  a_r4_two_words_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == VS_HI) |=> !vec_valid_o);
  a_r1_r2_r3_known_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_addr_o == HwBase || vec_addr_o == HwBase + 1'b1 ||
                     vec_addr_o == BrkBase || vec_addr_o == BrkBase + 1'b1));
endmodule

// File: rtl/hvc_halt_reg.sv
`timescale 1ns/1ps
module hvc_halt_reg #(
  parameter int DATA_W   = 8,
  parameter int HALT_BIT = 0,
  parameter int IRQ_W    = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wdt_irq_i,
  input  logic [IRQ_W-1:0]  irq_req_i,
  input  logic [IRQ_W-1:0]  irq_en_i,
  output logic              halt_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic halt_q;
  logic wake;

  assign wake = wdt_irq_i | (|(irq_req_i & irq_en_i));

  // falling-edge register: gate downstream only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              halt_q <= 1'b0;
    else if (we_i)            halt_q <= wdata_i[HALT_BIT];
    else if (halt_q && wake)  halt_q <= 1'b0;
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[HALT_BIT] = halt_q;
  end

  assign halt_o = halt_q;

  a_r5_enter: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[HALT_BIT]) |=> halt_o);
  a_r6_wdt_release: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (halt_o && !we_i && wdt_irq_i) |=> !halt_o);
  a_r7_masked_hold: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (halt_o && !we_i && !wdt_irq_i && !(|(irq_req_i & irq_en_i))) |=> halt_o);
endmodule

// File: rtl/hvc_clk_gate.sv
`timescale 1ns/1ps
module hvc_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  assign gclk_o = clk_i & en_i;

  always @(en_i) begin
    if (rst_ni === 1'b1)
      a_r10_gate_moves_low: assert (clk_i == 1'b0);
  end
endmodule

// File: rtl/halt_vec_ctrl.sv
`timescale 1ns/1ps
module halt_vec_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int LVL_W       = 2,
  parameter int EN_REGS     = 7,
  parameter int EN_BITS     = 8,
  parameter int HALT_BIT    = 0,
  parameter int HW_VEC      = 2,
  parameter int BRK_VEC     = 4,
  parameter int BRK_MAX_LVL = 2,
  localparam int IRQ_W      = EN_REGS * EN_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        hw_cause_i,
  input  logic              brk_rst_i,
  input  logic [LVL_W-1:0]  brk_lvl_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              wdt_irq_i,
  input  logic [IRQ_W-1:0]  irq_req_i,
  input  logic [IRQ_W-1:0]  irq_en_i,
  output logic              cpu_clk_o,
  output logic              halt_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              vec_valid_o
);
  hvc_vec_sel #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .N_HW(4),
    .HW_VEC(HW_VEC), .BRK_VEC(BRK_VEC), .BRK_MAX_LVL(BRK_MAX_LVL)
  ) u_vec (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_cause_i(hw_cause_i),
    .brk_rst_i(brk_rst_i), .brk_lvl_i(brk_lvl_i),
    .vec_addr_o(vec_addr_o), .vec_valid_o(vec_valid_o)
  );

  hvc_halt_reg #(.DATA_W(DATA_W), .HALT_BIT(HALT_BIT), .IRQ_W(IRQ_W)) u_halt (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .wdt_irq_i(wdt_irq_i), .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
    .halt_o(halt_o), .rdata_o(reg_rdata_o)
  );

  hvc_clk_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(!halt_o), .gclk_o(cpu_clk_o)
  );
endmodule

// File: tb/sim_halt_vec_ctrl.sv
`timescale 1ns/1ps
module sim_halt_vec_ctrl;
  localparam int EN_REGS = 2;
  localparam int EN_BITS = 4;
  localparam int IRQ_W   = EN_REGS * EN_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] hw_cause = '0;
  logic brk = 1'b0;
  logic [1:0] lvl = '0;
  logic we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic wdt = 1'b0;
  logic [IRQ_W-1:0] req = '0;
  logic [IRQ_W-1:0] en = '0;
  logic cpu_clk, halt;
  logic [15:0] vaddr;
  logic vvalid;

  int checks = 0;
  int errors = 0;
  int gate_bad = 0;

  always #10 clk = ~clk;

  halt_vec_ctrl #(.EN_REGS(EN_REGS), .EN_BITS(EN_BITS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hw_cause_i(hw_cause), .brk_rst_i(brk),
    .brk_lvl_i(lvl), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .wdt_irq_i(wdt), .irq_req_i(req), .irq_en_i(en), .cpu_clk_o(cpu_clk),
    .halt_o(halt), .vec_addr_o(vaddr), .vec_valid_o(vvalid)
  );

  // R10: gated clock edges must line up with system clock edges
  always @(cpu_clk) begin
    if (rst_n === 1'b1 && $time > 0) begin
      if (cpu_clk === 1'b1 && ($time % 20) != 10) gate_bad++;
      if (cpu_clk === 1'b0 && ($time % 20) != 0)  gate_bad++;
    end
  end

  task automatic chk(input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  task automatic run_reset(input logic [3:0] cause, input logic b,
                           input logic [1:0] l, input logic [15:0] base,
                           input string tag);
    @(posedge clk); #2 rst_n = 1'b0; hw_cause = cause; brk = b; lvl = l;
    repeat (3) @(posedge clk);
    #5 chk("R4", {tag, " valid in reset"}, 32'(vvalid), 0);
    chk("R9", {tag, " halt in reset"}, 32'(halt), 0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(posedge clk); #5;
    chk(tag, "low word addr", 32'(vaddr), 32'(base));
    chk("R4", {tag, " valid low word"}, 32'(vvalid), 1);
    hw_cause = '0; brk = 1'b0; lvl = '0;
    @(posedge clk); #5;
    chk("R4", {tag, " high word addr"}, 32'(vaddr), 32'(base + 16'd1));
    chk("R4", {tag, " valid high word"}, 32'(vvalid), 1);
    @(posedge clk); #5;
    chk("R4", {tag, " valid drops"}, 32'(vvalid), 0);
  endtask

  task automatic enter_halt();
    @(posedge clk); #2 we = 1'b1; wdata = 8'h01;
    @(posedge clk); #2 we = 1'b0; wdata = 8'h00;
    #3;
  endtask

  task automatic t_halt_entry();
    enter_halt();
    chk("R5", "halt set", 32'(halt), 1);
    chk("R5", "cpu clk low while clk high", 32'(cpu_clk), 0);
    chk("R11", "readback halted", 32'(rdata), 32'h01);
  endtask

  task automatic t_wdt_release();
    @(posedge clk); #2 wdt = 1'b1;
    #3 chk("R6", "held before falling edge", 32'(halt), 1);
    @(posedge clk); #2 wdt = 1'b0;
    #3 chk("R6", "released", 32'(halt), 0);
    chk("R6", "cpu clk running", 32'(cpu_clk), 1);
    chk("R11", "readback running", 32'(rdata), 32'h00);
  endtask

  task automatic t_masked(input int k);
    enter_halt();
    @(posedge clk); #2 req[k] = 1'b1; en = ~(IRQ_W'(1) << k);
    repeat (3) @(posedge clk);
    #5 chk("R7", $sformatf("masked line %0d holds", k), 32'(halt), 1);
    @(posedge clk); #2 en[k] = 1'b1;
    @(posedge clk); #5 chk("R7", $sformatf("enabled line %0d releases", k), 32'(halt), 0);
    #0 req = '0; en = '0;
  endtask

  task automatic t_pending();
    @(posedge clk); #2 req[1] = 1'b1; en[1] = 1'b1; we = 1'b1; wdata = 8'hFF;
    @(posedge clk); #2 we = 1'b0; wdata = 8'h00;
    #3 chk("R8", "halt set despite pending", 32'(halt), 1);
    chk("R11", "other bits zero", 32'(rdata), 32'h01);
    @(posedge clk); #5 chk("R8", "released next falling edge", 32'(halt), 0);
    req = '0; en = '0;
  endtask

  task automatic t_reset_in_halt();
    enter_halt();
    chk("R9", "halted before reset", 32'(halt), 1);
    run_reset(4'b0001, 1'b0, 2'd0, 16'h0002, "R1");
    @(posedge clk); #5;
    chk("R9", "halt cleared", 32'(halt), 0);
    chk("R9", "cpu clk follows", 32'(cpu_clk), 1);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 chk("R4", "valid in reset", 32'(vvalid), 0);
    chk("R11", "readback reset", 32'(rdata), 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int i = 0; i < 4; i++)
      run_reset(4'(1 << i), 1'b0, 2'd0, 16'h0002, "R1");
    run_reset(4'b1000, 1'b1, 2'd0, 16'h0002, "R1");
    run_reset(4'b0000, 1'b1, 2'd0, 16'h0004, "R2");
    run_reset(4'b0000, 1'b1, 2'd1, 16'h0004, "R2");
    run_reset(4'b0000, 1'b1, 2'd2, 16'h0002, "R3");
    run_reset(4'b0000, 1'b1, 2'd3, 16'h0002, "R3");
    t_halt_entry();
    t_wdt_release();
    for (int k = 0; k < IRQ_W; k++) t_masked(k);
    t_pending();
    t_reset_in_halt();
    chk("R10", "gated clock edge alignment", 32'(gate_bad), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule